// File: doc/BRIEF.md
# Page Write Stager with Timed Commit

This block sits between a two-wire serial slave front end and a byte-wide memory array. The front end sends it already-decoded events: a START or repeated START, a STOP, the word-address byte of a write transaction, and each data byte that follows. The block keeps the word address and holds up to one page of data bytes in a local buffer. Nothing reaches the array until the transaction closes with a STOP.

On a STOP that follows at least one data byte, the block starts a write cycle of fixed length, counted in system clocks. During this cycle it copies the buffered bytes into the array, one per clock, in ascending address order. For the whole cycle it raises `busy_o`. The front end uses this flag to ignore the bus and to withhold the acknowledge of the device address, which is how a master polls for completion.

A transaction that ends in a repeated START instead of a STOP leaves the array untouched. The internal address pointer, which reads also use, follows the word address as it is received and moves past the last committed byte after a commit.

Top module: `pwb_write_stager`

## Requirements
- R1: During and after reset, with no stimulus, `busy_o` and `mem_we_o` are low and `ptr_o` is 0.
- R2: When idle, a word-address pulse loads the start address and copies it to `ptr_o` in the next cycle. The start address splits into a page (bits [7:3]) and an offset within the page (bits [2:0]).
- R3: A STOP that follows at least one data byte raises `busy_o` in the cycle after the STOP is sampled. `busy_o` then stays high for exactly `WR_CYCLES` cycles and drops on the next one.
- R4: The commit writes min(n, 8) bytes, where n is the number of data bytes received. It writes one byte per clock in the first cycles of the busy window. The addresses go up from the start address, and the offset wraps within the page (offset 7 is followed by offset 0 of the same page).
- R5: Data bytes fill the page buffer at successive offsets that wrap on three bits. A ninth data byte therefore replaces the byte at the start offset, and the commit stores that ninth byte there.
- R6: From the cycle after the STOP, `ptr_o` holds the address of the last byte written in commit order plus one, modulo 256 (0xFF is followed by 0x00).
- R7: A START or repeated START received before a STOP discards the buffered bytes. No array write follows, `busy_o` stays low, and `ptr_o` keeps the word address.
- R8: A STOP that comes after the word address but before any data byte causes no array write and no busy window. `ptr_o` keeps the word address.
- R9: While `busy_o` is high, every input event is ignored: START, STOP, word address and data. No extra array write results, `ptr_o` does not change, and the busy window keeps its length.
- R10: Data or STOP pulses that arrive with no word address since the last START or STOP cause no array write.
- R11: Once `busy_o` has dropped, a new transaction is accepted and committed normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse: START or repeated START seen on the bus |
| stop_i | input | 1 | One-cycle pulse: STOP seen on the bus |
| addr_wr_i | input | 1 | One-cycle pulse: word-address byte of a write received |
| addr_byte_i | input | 8 | Word-address byte, valid with `addr_wr_i` |
| data_wr_i | input | 1 | One-cycle pulse: data byte received |
| data_byte_i | input | 8 | Data byte, valid with `data_wr_i` |
| busy_o | output | 1 | High for the whole internal write cycle |
| mem_we_o | output | 1 | Array write strobe |
| mem_addr_o | output | 8 | Array write address |
| mem_wdata_o | output | 8 | Array write data |
| ptr_o | output | 8 | Current address pointer |

## Verification
Each input pulse is driven on a falling edge and sampled at the next rising edge, so the results are due at fixed times. `ptr_o` updates one edge after a word-address or STOP pulse. `busy_o` rises one edge after the STOP. The k-th array write lands on the k-th rising edge after the STOP, and `busy_o` falls `WR_CYCLES` edges after the STOP. The bench samples every output on the falling edge that follows the edge where the result is due. It measures the busy window by counting falling-edge samples from the first one after the STOP. It records every array write in a model memory and in an ordered address log, so the address order, the overwrite and any write that should not happen are all seen at the write port.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

    // Collection phase of a write transaction
    typedef enum logic [0:0] {
        PWB_IDLE    = 1'b0,  // waiting for a word address
        PWB_COLLECT = 1'b1   // word address taken, gathering data bytes
    } pwb_state_e;

endpackage

// File: rtl/pwb_page_buf.sv
module pwb_page_buf #(
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 8,
    localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [OFF_W-1:0]  wr_off_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [OFF_W-1:0]  rd_off_i,
    output logic [DATA_W-1:0] rd_data_o
);

    logic [DATA_W-1:0] slot_q [PAGE_BYTES];
    logic [DATA_W-1:0] slot_d [PAGE_BYTES];

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        always_comb begin
            slot_d[g] = slot_q[g];
            if (wr_i && (wr_off_i == OFF_W'(g))) begin
                slot_d[g] = wr_data_i;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else begin
                slot_q[g] <= slot_d[g];
            end
        end
    end

    assign rd_data_o = slot_q[rd_off_i];

endmodule

// File: rtl/pwb_commit_timer.sv
module pwb_commit_timer #(
    parameter int PAGE_BYTES = 8,
    parameter int WR_CYCLES  = 40,
    localparam int CNT_W     = $clog2(PAGE_BYTES + 1),
    localparam int TMR_W     = $clog2(WR_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic [CNT_W-1:0] nbytes_i,
    output logic             busy_o,
    output logic             we_o,
    output logic [CNT_W-1:0] idx_o
);

    typedef struct packed {
        logic             busy;
        logic [TMR_W-1:0] remain;
        logic [CNT_W-1:0] idx;
        logic [CNT_W-1:0] nbytes;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (!tmr_q.busy) begin
            if (go_i) begin
                tmr_d.busy   = 1'b1;
                tmr_d.remain = TMR_W'(WR_CYCLES - 1);
                tmr_d.idx    = '0;
                tmr_d.nbytes = nbytes_i;
            end
        end else begin
            if (tmr_q.idx < tmr_q.nbytes) begin
                tmr_d.idx = tmr_q.idx + 1'b1;
            end
            if (tmr_q.remain == '0) begin
                tmr_d.busy = 1'b0;
            end else begin
                tmr_d.remain = tmr_q.remain - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign busy_o = tmr_q.busy;
    assign we_o   = tmr_q.busy && (tmr_q.idx < tmr_q.nbytes);
    assign idx_o  = tmr_q.idx;

endmodule

// File: rtl/pwb_write_stager.sv
module pwb_write_stager #(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 8,
    parameter int WR_CYCLES  = 40,
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int PAGE_W    = ADDR_W - OFF_W,
    localparam int CNT_W     = $clog2(PAGE_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              addr_wr_i,
    input  logic [ADDR_W-1:0] addr_byte_i,
    input  logic              data_wr_i,
    input  logic [DATA_W-1:0] data_byte_i,
    output logic              busy_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic [ADDR_W-1:0] ptr_o
);
    import pwb_pkg::*;

    typedef struct packed {
        pwb_state_e        state;
        logic [PAGE_W-1:0] page;
        logic [OFF_W-1:0]  start_off;
        logic [OFF_W-1:0]  wr_off;
        logic [CNT_W-1:0]  count;
        logic [ADDR_W-1:0] ptr;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             buf_wr;
    logic             commit_go;
    logic             tmr_busy;
    logic             tmr_we;
    logic [CNT_W-1:0] tmr_idx;
    logic [OFF_W-1:0] rd_off;
    logic [OFF_W-1:0] last_off;

    // Offset of the final byte in commit order; a full page ends one below the start
    assign last_off = ctl_q.start_off + ctl_q.count[OFF_W-1:0] - 1'b1;

    always_comb begin
        ctl_d     = ctl_q;
        buf_wr    = 1'b0;
        commit_go = 1'b0;
        if (!tmr_busy) begin
            if (start_i) begin
                // new transaction or repeated START: staged bytes are dropped
                ctl_d.state = PWB_IDLE;
                ctl_d.count = '0;
            end else if (stop_i) begin
                if ((ctl_q.state == PWB_COLLECT) && (ctl_q.count != '0)) begin
                    commit_go = 1'b1;
                    ctl_d.ptr = {ctl_q.page, last_off} + ADDR_W'(1);
                end
                ctl_d.state = PWB_IDLE;
            end else if (addr_wr_i && (ctl_q.state == PWB_IDLE)) begin
                ctl_d.state     = PWB_COLLECT;
                ctl_d.page      = addr_byte_i[ADDR_W-1:OFF_W];
                ctl_d.start_off = addr_byte_i[OFF_W-1:0];
                ctl_d.wr_off    = addr_byte_i[OFF_W-1:0];
                ctl_d.count     = '0;
                ctl_d.ptr       = addr_byte_i;
            end else if (data_wr_i && (ctl_q.state == PWB_COLLECT)) begin
                buf_wr       = 1'b1;
                ctl_d.wr_off = ctl_q.wr_off + 1'b1;
                if (ctl_q.count != CNT_W'(PAGE_BYTES)) begin
                    ctl_d.count = ctl_q.count + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rd_off = ctl_q.start_off + tmr_idx[OFF_W-1:0];

    pwb_page_buf #(
        .DATA_W     (DATA_W),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (buf_wr),
        .wr_off_i  (ctl_q.wr_off),
        .wr_data_i (data_byte_i),
        .rd_off_i  (rd_off),
        .rd_data_o (mem_wdata_o)
    );

    pwb_commit_timer #(
        .PAGE_BYTES (PAGE_BYTES),
        .WR_CYCLES  (WR_CYCLES)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .go_i     (commit_go),
        .nbytes_i (ctl_q.count),
        .busy_o   (tmr_busy),
        .we_o     (tmr_we),
        .idx_o    (tmr_idx)
    );

    assign busy_o     = tmr_busy;
    assign mem_we_o   = tmr_we;
    assign mem_addr_o = {ctl_q.page, rd_off};
    assign ptr_o      = ctl_q.ptr;

endmodule

// File: rtl/pwb_write_stager_chk.sv
module pwb_write_stager_chk #(
    parameter int ADDR_W     = 8,
    parameter int PAGE_BYTES = 8,
    parameter int WR_CYCLES  = 40,
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int LEN_W     = $clog2(WR_CYCLES + 2)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              stop_i,
    input logic              busy_o,
    input logic              mem_we_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [ADDR_W-1:0] ptr_o
);

    logic [LEN_W-1:0] win_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0;
        end else if (busy_o) begin
            win_q <= win_q + 1'b1;
        end else begin
            win_q <= '0;
        end
    end

    AST_WRITE_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> busy_o); // R4

    AST_BUSY_FOLLOWS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(stop_i)); // R3

    AST_BUSY_WINDOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy_o) && (win_q != '0)) |-> (win_q == LEN_W'(WR_CYCLES))); // R3

    AST_BUSY_NOT_OVERLONG: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (win_q < LEN_W'(WR_CYCLES))); // R3

    AST_PTR_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(ptr_o)); // R9

    AST_ADDR_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && $past(mem_we_o)) |->
        (mem_addr_o[OFF_W-1:0] == OFF_W'($past(mem_addr_o[OFF_W-1:0]) + 1'b1))); // R4

    AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && $past(mem_we_o)) |->
        (mem_addr_o[ADDR_W-1:OFF_W] == $past(mem_addr_o[ADDR_W-1:OFF_W]))); // R4

    AST_START_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !stop_i && !busy_o) |=> !busy_o); // R7

endmodule

bind pwb_write_stager pwb_write_stager_chk #(
    .ADDR_W     (ADDR_W),
    .PAGE_BYTES (PAGE_BYTES),
    .WR_CYCLES  (WR_CYCLES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .stop_i     (stop_i),
    .busy_o     (busy_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .ptr_o      (ptr_o)
);

// File: tb/pwb_write_stager_tb.sv
module pwb_write_stager_tb;

    localparam int WR = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       stop_i = 1'b0;
    logic       addr_wr_i = 1'b0;
    logic [7:0] addr_byte_i = '0;
    logic       data_wr_i = 1'b0;
    logic [7:0] data_byte_i = '0;
    logic       busy_o;
    logic       mem_we_o;
    logic [7:0] mem_addr_o;
    logic [7:0] mem_wdata_o;
    logic [7:0] ptr_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    logic [7:0] mem [256];
    logic [7:0] wlog [64];
    int wcnt = 0;

    always #2.5 clk = ~clk;

    pwb_write_stager #(.WR_CYCLES(WR)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .start_i(start_i), .stop_i(stop_i),
        .addr_wr_i(addr_wr_i), .addr_byte_i(addr_byte_i),
        .data_wr_i(data_wr_i), .data_byte_i(data_byte_i),
        .busy_o(busy_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .ptr_o(ptr_o)
    );

    // model array: records every write the block issues
    always @(posedge clk) begin
        cyc++;
        if (rst_n && mem_we_o) begin
            mem[mem_addr_o] = mem_wdata_o;
            if (wcnt < 64) wlog[wcnt] = mem_addr_o;
            wcnt++;
        end
    end

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            if (cyc > 100000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual cycle %0d expected end before 100000", cyc);
                report();
            end
        end
    end

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    endtask
    task automatic pulse_stop();
        stop_i = 1'b1; @(negedge clk); stop_i = 1'b0;
    endtask
    task automatic pulse_addr(input logic [7:0] a);
        addr_wr_i = 1'b1; addr_byte_i = a; @(negedge clk); addr_wr_i = 1'b0;
    endtask
    task automatic pulse_data(input logic [7:0] d);
        data_wr_i = 1'b1; data_byte_i = d; @(negedge clk); data_wr_i = 1'b0;
    endtask

    // counts falling-edge samples with busy high, starting with the current one
    task automatic wait_busy(inout int len);
        while (busy_o && len < 1000) begin
            len++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        check("R1 busy", busy_o, 0);
        check("R1 we", mem_we_o, 0);
        check("R1 ptr", ptr_o, 0);
    endtask

    task automatic t_single();
        int len = 0;
        int w0 = wcnt;
        pulse_start();
        pulse_addr(8'h10);
        check("R2 ptr after address", ptr_o, 8'h10);
        pulse_data(8'hA5);
        pulse_stop();
        check("R3 busy after stop", busy_o, 1);
        check("R6 ptr after single", ptr_o, 8'h11);
        wait_busy(len);
        check("R3 busy length", len, WR);
        check("R4 single write count", wcnt - w0, 1);
        check("R4 single data", mem[8'h10], 8'hA5);
    endtask

    task automatic t_full_page();
        int len = 0;
        int w0 = wcnt;
        pulse_start();
        pulse_addr(8'h20);
        for (int i = 0; i < 8; i++) pulse_data(8'h30 + 8'(i));
        pulse_stop();
        check("R6 ptr full page", ptr_o, 8'h28);
        wait_busy(len);
        check("R3 busy length page", len, WR);
        check("R4 page write count", wcnt - w0, 8);
        for (int i = 0; i < 8; i++) begin
            check("R4 page data", mem[8'h20 + 8'(i)], 8'h30 + i);
            check("R4 page order", wlog[w0 + i], 8'h20 + i);
        end
    endtask

    task automatic t_wrap();
        int len = 0;
        int w0 = wcnt;
        logic [7:0] exp_a [4] = '{8'h2D, 8'h2E, 8'h2F, 8'h28};
        pulse_start();
        pulse_addr(8'h2D);
        for (int i = 0; i < 4; i++) pulse_data(8'hC0 + 8'(i));
        pulse_stop();
        check("R6 ptr wrapped page", ptr_o, 8'h29);
        wait_busy(len);
        check("R4 wrap count", wcnt - w0, 4);
        for (int i = 0; i < 4; i++) begin
            check("R4 wrap order", wlog[w0 + i], exp_a[i]);
            check("R4 wrap data", mem[exp_a[i]], 8'hC0 + i);
        end
    endtask

    task automatic t_ninth();
        int len = 0;
        int w0 = wcnt;
        pulse_start();
        pulse_addr(8'h40);
        for (int i = 0; i < 9; i++) pulse_data(8'hD0 + 8'(i));
        pulse_stop();
        check("R6 ptr after ninth", ptr_o, 8'h48);
        wait_busy(len);
        check("R5 ninth count", wcnt - w0, 8);
        check("R5 ninth overwrites start", mem[8'h40], 8'hD8);
        for (int i = 1; i < 8; i++) check("R5 others kept", mem[8'h40 + 8'(i)], 8'hD0 + i);
    endtask

    task automatic t_restart();
        int w0 = wcnt;
        pulse_start();
        pulse_addr(8'h60);
        pulse_data(8'h77);
        pulse_data(8'h78);
        pulse_start();
        check("R7 no busy after restart", busy_o, 0);
        pulse_stop();
        for (int i = 0; i < 4; i++) @(negedge clk);
        check("R7 no write after restart", wcnt - w0, 0);
        check("R7 cell untouched", mem[8'h60], 0);
        check("R7 ptr keeps address", ptr_o, 8'h60);
        check("R7 busy stays low", busy_o, 0);
    endtask

    task automatic t_addr_only();
        int w0 = wcnt;
        pulse_start();
        pulse_addr(8'h70);
        pulse_stop();
        check("R8 no busy", busy_o, 0);
        for (int i = 0; i < 3; i++) @(negedge clk);
        check("R8 no write", wcnt - w0, 0);
        check("R8 ptr keeps address", ptr_o, 8'h70);
    endtask

    task automatic t_no_addr();
        int w0 = wcnt;
        pulse_start();
        pulse_data(8'h99);
        pulse_stop();
        pulse_data(8'h9A);
        pulse_stop();
        for (int i = 0; i < 3; i++) @(negedge clk);
        check("R10 no write without address", wcnt - w0, 0);
        check("R10 busy low", busy_o, 0);
    endtask

    task automatic t_busy_ignore();
        int len = 0;
        int w0;
        pulse_start();
        pulse_addr(8'h80);
        pulse_data(8'h11);
        w0 = wcnt;
        pulse_stop();
        // events during the busy window, each sampled with busy high
        len++; pulse_start();
        len++; pulse_addr(8'h90);
        len++; pulse_data(8'h22);
        len++; pulse_stop();
        wait_busy(len);
        check("R9 busy length unchanged", len, WR);
        check("R9 single write only", wcnt - w0, 1);
        check("R9 ignored cell", mem[8'h90], 0);
        check("R9 ptr unchanged", ptr_o, 8'h81);
        // address was ignored, so these must not commit either
        pulse_data(8'h33);
        pulse_stop();
        for (int i = 0; i < 3; i++) @(negedge clk);
        check("R9 no late commit", wcnt - w0, 1);
    endtask

    task automatic t_after_busy();
        int len = 0;
        int w0 = wcnt;
        pulse_start();
        pulse_addr(8'hFE);
        pulse_data(8'hE1);
        pulse_data(8'hE2);
        pulse_stop();
        check("R6 ptr wraps to zero", ptr_o, 8'h00);
        wait_busy(len);
        check("R11 accepted after busy", wcnt - w0, 2);
        check("R11 data FE", mem[8'hFE], 8'hE1);
        check("R11 data FF", mem[8'hFF], 8'hE2);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_full_page();
        t_wrap();
        t_ninth();
        t_restart();
        t_addr_only();
        t_no_addr();
        t_busy_ignore();
        t_after_busy();
        done = 1;
        report();
    end

endmodule